// File: doc/BRIEF.md
# Dual-View Instruction Code Memory

This block holds the instruction stream of a small coprocessor and shows that one storage array in two ways. The fetch side is read-only. A 16-bit program counter selects one 16-bit instruction. Two instructions are packed into every 32-bit storage word. The system-bus side sees the same array as a word-wide memory at byte addresses, and it can both read and write it. A host uses the bus side to load a program and to inspect it. The coprocessor uses the fetch side to run that program.

The array has one port, so only one of the two sides can use it in a given cycle. A bus request that is accepted always takes the array. A fetch request made in the same cycle is stalled and is granted on the first cycle in which no bus access is being accepted. A bus access that is not word-sized, is not word-aligned, or lies beyond the implemented depth ends in an error response and leaves the storage unchanged. A fetch beyond the implemented depth returns a zero instruction.

Top module: `icm_code_mem`

## Requirements
- R1: Program counter value p reads storage word p>>1. When bit 0 of p is 0 the instruction is bits [15:0] of that word, and when it is 1 the instruction is bits [31:16].
- R2: `fetch_valid_o` is high in exactly the cycle after a cycle with `fetch_gnt_o` high. `fetch_instr_o` carries the instruction in that cycle and is zero whenever `fetch_valid_o` is low.
- R3: A bus request is accepted when `bus_req_i` is high and `bus_ready_o` is low. `bus_ready_o` is then high for exactly the next cycle. A legal word write at byte address a stores `bus_wdata_i` in word a>>2, and a later legal read of that address returns it on `bus_rdata_o`.
- R4: In a cycle where a bus request is accepted, `fetch_gnt_o` is low, and `fetch_stall_o` is high if `fetch_req_i` is high.
- R5: A held fetch request is granted in the first cycle without an accepted bus request, and it returns the instruction for the program counter presented in the grant cycle.
- R6: `bus_size_i` is encoded 0 for byte, 1 for halfword, 2 for word and 3 for reserved. Any value other than 2 gives `bus_err_o` high with `bus_ready_o`, and it writes nothing.
- R7: A bus address with bits [1:0] not equal to zero gives an error response and writes nothing.
- R8: A bus word index at or above `DEPTH_WORDS` gives an error response. A fetch whose word index p>>1 is at or above `DEPTH_WORDS` returns a zero instruction with `fetch_valid_o` high.
- R9: After reset, `bus_ready_o`, `bus_err_o` and `fetch_valid_o` are low, and `bus_rdata_o` is zero on error and write responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_req_i | input | 1 | Instruction fetch request |
| fetch_pc_i | input | PC_W | Program counter (halfword index) |
| fetch_gnt_o | output | 1 | Fetch uses the array this cycle |
| fetch_stall_o | output | 1 | Fetch requested but held off by the bus |
| fetch_valid_o | output | 1 | Instruction valid, one cycle after grant |
| fetch_instr_o | output | 16 | Fetched instruction |
| bus_req_i | input | 1 | Bus request, held until ready |
| bus_we_i | input | 1 | Bus write enable |
| bus_size_i | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 reserved |
| bus_addr_i | input | BUS_AW | Byte address within the memory window |
| bus_wdata_i | input | 32 | Write data |
| bus_ready_o | output | 1 | Response strobe, one cycle after acceptance |
| bus_err_o | output | 1 | Error response, valid with ready |
| bus_rdata_o | output | 32 | Read data, valid with ready |

## Verification
The checker watches every cycle for the arbitration rules. It checks that no fetch is granted while a bus request is being accepted, that stalls appear only when the bus is requesting, that ready and valid strobes follow acceptance and grant by one cycle, and that error responses carry zero data. The contents of memory can only be shown by the bench's scenarios. These include the halfword chosen for each program counter, a write landing at the word its byte address names, the storage left unchanged after an illegal access, and a stalled fetch returning the instruction of its held address. The bench fills a small array, reads it back through both views and through every program counter, and tries each bad size, offset and out-of-range index.

// File: rtl/icm_pkg.sv
package icm_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = 16;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } bus_size_e;

  typedef struct packed {
    logic rsp;     // bus response due
    logic err;     // error response
    logic wr;      // write response, no data
    logic fvld;    // fetch data due
    logic fhsel;   // upper halfword
    logic foor;    // fetch beyond depth
  } rsp_state_t;
endpackage

// File: rtl/icm_xlate.sv
module icm_xlate #(
  parameter int unsigned DEPTH_WORDS = 1024,
  parameter int unsigned BUS_AW      = 17,
  parameter int unsigned PC_W        = 16,
  parameter int unsigned IDX_W       = 10
) (
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [1:0]        bus_size_i,
  input  logic [PC_W-1:0]   fetch_pc_i,
  output logic [IDX_W-1:0]  bus_idx_o,
  output logic              bus_bad_o,
  output logic [IDX_W-1:0]  fetch_idx_o,
  output logic              fetch_hsel_o,
  output logic              fetch_oor_o
);
  import icm_pkg::*;

  localparam int unsigned BW = BUS_AW - 2;
  localparam int unsigned FW = PC_W - 1;

  logic [BW-1:0] bus_word;
  logic [FW-1:0] fetch_word;
  logic          bus_oor, bus_misal, bus_size_bad;

  // byte address -> word index; pc -> word index + halfword select
  assign bus_word   = bus_addr_i[BUS_AW-1:2];
  assign fetch_word = fetch_pc_i[PC_W-1:1];

  assign bus_oor      = 32'(bus_word) >= DEPTH_WORDS;
  assign bus_misal    = |bus_addr_i[1:0];
  assign bus_size_bad = bus_size_e'(bus_size_i) != SZ_WORD;
  assign bus_bad_o    = bus_oor | bus_misal | bus_size_bad;

  assign bus_idx_o    = bus_word[IDX_W-1:0];
  assign fetch_idx_o  = fetch_word[IDX_W-1:0];
  assign fetch_hsel_o = fetch_pc_i[0];
  assign fetch_oor_o  = 32'(fetch_word) >= DEPTH_WORDS;
endmodule

// File: rtl/icm_arb.sv
module icm_arb (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_req_i,
  input  logic                 bus_we_i,
  input  logic                 bus_bad_i,
  input  logic                 fetch_req_i,
  input  logic                 fetch_hsel_i,
  input  logic                 fetch_oor_i,
  output logic                 bus_acc_o,
  output logic                 fetch_gnt_o,
  output logic                 mem_en_o,
  output logic                 mem_we_o,
  output icm_pkg::rsp_state_t  st_o
);
  import icm_pkg::*;

  rsp_state_t st_q, st_d;

  // bus wins; a pending response blocks re-acceptance of a held request
  assign bus_acc_o   = bus_req_i & ~st_q.rsp;
  assign fetch_gnt_o = fetch_req_i & ~bus_acc_o;

  assign mem_en_o = bus_acc_o ? ~bus_bad_i : (fetch_gnt_o & ~fetch_oor_i);
  assign mem_we_o = bus_acc_o & bus_we_i & ~bus_bad_i;

  always_comb begin
    st_d       = '0;
    st_d.rsp   = bus_acc_o;
    st_d.err   = bus_acc_o & bus_bad_i;
    st_d.wr    = bus_acc_o & bus_we_i;
    st_d.fvld  = fetch_gnt_o;
    st_d.fhsel = fetch_gnt_o & fetch_hsel_i;
    st_d.foor  = fetch_gnt_o & fetch_oor_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/icm_store.sv
module icm_store #(
  parameter int unsigned DEPTH_WORDS = 1024,
  parameter int unsigned IDX_W       = 10
) (
  input  logic                        clk_i,
  input  logic                        en_i,
  input  logic                        we_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic [icm_pkg::WORD_W-1:0]  wdata_i,
  output logic [icm_pkg::WORD_W-1:0]  rdata_o
);
  import icm_pkg::*;

  logic [WORD_W-1:0] mem_q [DEPTH_WORDS];
  logic [WORD_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem_q[idx_i] <= wdata_i;
      else      rdata_q      <= mem_q[idx_i];
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/icm_code_mem.sv
module icm_code_mem #(
  parameter int unsigned DEPTH_WORDS = 1024,
  parameter int unsigned BUS_AW      = 17,
  parameter int unsigned PC_W        = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_req_i,
  input  logic [PC_W-1:0]   fetch_pc_i,
  output logic              fetch_gnt_o,
  output logic              fetch_stall_o,
  output logic              fetch_valid_o,
  output logic [15:0]       fetch_instr_o,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_size_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic              bus_ready_o,
  output logic              bus_err_o,
  output logic [31:0]       bus_rdata_o
);
  import icm_pkg::*;

  localparam int unsigned IDX_W = (DEPTH_WORDS > 1) ? $clog2(DEPTH_WORDS) : 1;

  logic [IDX_W-1:0] bus_idx, fetch_idx, mem_idx;
  logic             bus_bad, fetch_hsel, fetch_oor;
  logic             bus_acc, mem_en, mem_we;
  logic [WORD_W-1:0] mem_rdata;
  rsp_state_t       st;

  icm_xlate #(
    .DEPTH_WORDS(DEPTH_WORDS), .BUS_AW(BUS_AW), .PC_W(PC_W), .IDX_W(IDX_W)
  ) u_xlate (
    .bus_addr_i  (bus_addr_i),
    .bus_size_i  (bus_size_i),
    .fetch_pc_i  (fetch_pc_i),
    .bus_idx_o   (bus_idx),
    .bus_bad_o   (bus_bad),
    .fetch_idx_o (fetch_idx),
    .fetch_hsel_o(fetch_hsel),
    .fetch_oor_o (fetch_oor)
  );

  icm_arb u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_req_i   (bus_req_i),
    .bus_we_i    (bus_we_i),
    .bus_bad_i   (bus_bad),
    .fetch_req_i (fetch_req_i),
    .fetch_hsel_i(fetch_hsel),
    .fetch_oor_i (fetch_oor),
    .bus_acc_o   (bus_acc),
    .fetch_gnt_o (fetch_gnt_o),
    .mem_en_o    (mem_en),
    .mem_we_o    (mem_we),
    .st_o        (st)
  );

  assign mem_idx = bus_acc ? bus_idx : fetch_idx;

  icm_store #(.DEPTH_WORDS(DEPTH_WORDS), .IDX_W(IDX_W)) u_store (
    .clk_i  (clk_i),
    .en_i   (mem_en),
    .we_i   (mem_we),
    .idx_i  (mem_idx),
    .wdata_i(bus_wdata_i),
    .rdata_o(mem_rdata)
  );

  assign fetch_stall_o = fetch_req_i & ~fetch_gnt_o;
  assign fetch_valid_o = st.fvld;
  assign fetch_instr_o = (st.fvld && !st.foor)
                         ? (st.fhsel ? mem_rdata[31:16] : mem_rdata[15:0]) : '0;

  assign bus_ready_o = st.rsp;
  assign bus_err_o   = st.err;
  assign bus_rdata_o = (st.rsp && !st.err && !st.wr) ? mem_rdata : '0;
endmodule

// File: rtl/icm_code_mem_chk.sv
module icm_code_mem_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        fetch_req_i,
  input logic        fetch_gnt_o,
  input logic        fetch_stall_o,
  input logic        fetch_valid_o,
  input logic [15:0] fetch_instr_o,
  input logic        bus_req_i,
  input logic        bus_ready_o,
  input logic        bus_err_o,
  input logic [31:0] bus_rdata_o
);
  // R4: accepted bus access excludes a fetch grant
  assert_bus_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_ready_o) |-> !fetch_gnt_o);

  // R4: a stall only occurs when the bus is requesting
  assert_stall_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_stall_o |-> (bus_req_i && fetch_req_i));

  assert_ready_follows_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_ready_o) |=> bus_ready_o);

  assert_ready_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ready_o |=> !bus_ready_o);

  assert_valid_after_gnt_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_gnt_o |=> fetch_valid_o);

  assert_no_spurious_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_gnt_o |=> !fetch_valid_o);

  assert_instr_zero_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_o |-> (fetch_instr_o == 16'h0));

  assert_err_with_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> bus_ready_o);

  assert_err_no_data_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> (bus_rdata_o == 32'h0));

  assert_rsp_exclusive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_ready_o && fetch_valid_o));
endmodule

bind icm_code_mem icm_code_mem_chk u_chk (.*);

// File: tb/icm_code_mem_tb.sv
`timescale 1ns/1ps
module icm_code_mem_tb;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned AW    = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_req = 1'b0;
  logic [15:0] fetch_pc = '0;
  logic        fetch_gnt, fetch_stall, fetch_valid;
  logic [15:0] fetch_instr;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_size = 2'd2;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready, bus_err;
  logic [31:0] bus_rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  icm_code_mem #(.DEPTH_WORDS(DEPTH), .BUS_AW(AW), .PC_W(16)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_req_i(fetch_req), .fetch_pc_i(fetch_pc),
    .fetch_gnt_o(fetch_gnt), .fetch_stall_o(fetch_stall),
    .fetch_valid_o(fetch_valid), .fetch_instr_o(fetch_instr),
    .bus_req_i(bus_req), .bus_we_i(bus_we), .bus_size_i(bus_size),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_ready_o(bus_ready), .bus_err_o(bus_err), .bus_rdata_o(bus_rdata)
  );

  function automatic logic [31:0] pat(int i);
    return {8'(i + 48), 8'(i ^ 90), 8'(i * 3), 8'(255 - i)};
  endfunction

  function automatic logic [15:0] exp_instr(int p);
    logic [31:0] w;
    if ((p >> 1) >= int'(DEPTH)) return 16'h0;
    w = pat(p >> 1);
    return (p % 2 == 1) ? w[31:16] : w[15:0];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic bus_xfer(input logic we, input logic [1:0] sz, input int addr,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output logic er, output logic rdy);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_size = sz; bus_addr = AW'(addr); bus_wdata = wd;
    @(negedge clk);
    rdy = bus_ready; er = bus_err; rd = bus_rdata;
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic fetch(input int p, output logic [15:0] ins, output logic vld,
                       output logic gnt);
    @(negedge clk);
    fetch_req = 1'b1; fetch_pc = 16'(p);
    #1 gnt = fetch_gnt;
    @(negedge clk);
    vld = fetch_valid; ins = fetch_instr;
    fetch_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    finish_up();
  end

  initial begin
    logic [31:0] rd;
    logic er, rdy, vld, gnt;
    logic [15:0] ins;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check("R9 ready", 32'(bus_ready), 0);
    check("R9 err", 32'(bus_err), 0);
    check("R9 valid", 32'(fetch_valid), 0);

    // R3: fill every word
    for (int i = 0; i < int'(DEPTH); i++) begin
      bus_xfer(1'b1, 2'd2, i * 4, pat(i), rd, er, rdy);
      check("R3 wr ready", 32'(rdy), 1);
      check("R3 wr err", 32'(er), 0);
      check("R9 wr rdata zero", rd, 0);
    end
    for (int i = 0; i < int'(DEPTH); i++) begin
      bus_xfer(1'b0, 2'd2, i * 4, 32'h0, rd, er, rdy);
      check("R3 read back", rd, pat(i));
    end

    // R1 R2 R8: every pc, plus a few beyond depth
    for (int p = 0; p < int'(2 * DEPTH) + 4; p++) begin
      fetch(p, ins, vld, gnt);
      check("R2 gnt", 32'(gnt), 1);
      check("R2 valid", 32'(vld), 1);
      if (p >= int'(2 * DEPTH)) check("R8 fetch oor zero", 32'(ins), 32'(exp_instr(p)));
      else                      check("R1 halfword", 32'(ins), 32'(exp_instr(p)));
    end
    @(negedge clk);
    check("R2 valid drops", 32'(fetch_valid), 0);

    // R6: illegal sizes write nothing
    for (int s = 0; s < 4; s++) begin
      if (s == 2) continue;
      bus_xfer(1'b1, 2'(s), 20, 32'hDEAD_BEEF, rd, er, rdy);
      check("R6 size err", 32'(er), 1);
      check("R6 size ready", 32'(rdy), 1);
      check("R9 err rdata zero", rd, 0);
      bus_xfer(1'b0, 2'(s), 20, 32'h0, rd, er, rdy);
      check("R6 size rd err", 32'(er), 1);
    end
    bus_xfer(1'b0, 2'd2, 20, 32'h0, rd, er, rdy);
    check("R6 unchanged", rd, pat(5));

    // R7: misaligned offsets write nothing
    for (int o = 1; o < 4; o++) begin
      bus_xfer(1'b1, 2'd2, 24 + o, 32'h1234_5678, rd, er, rdy);
      check("R7 misalign err", 32'(er), 1);
    end
    bus_xfer(1'b0, 2'd2, 24, 32'h0, rd, er, rdy);
    check("R7 unchanged", rd, pat(6));

    // R8: bus beyond depth
    for (int w = int'(DEPTH); w < int'(DEPTH) + 3; w++) begin
      bus_xfer(1'b1, 2'd2, w * 4, 32'hCAFE_0000, rd, er, rdy);
      check("R8 bus oor err", 32'(er), 1);
    end
    bus_xfer(1'b0, 2'd2, (int'(DEPTH) - 1) * 4, 32'h0, rd, er, rdy);
    check("R8 last word ok", 32'(er), 0);
    check("R8 last word data", rd, pat(int'(DEPTH) - 1));

    // R4 R5: collision, bus wins, held fetch granted next
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_size = 2'd2; bus_addr = AW'(32);
    fetch_req = 1'b1; fetch_pc = 16'd5;
    #1;
    check("R4 gnt low", 32'(fetch_gnt), 0);
    check("R4 stall high", 32'(fetch_stall), 1);
    @(negedge clk);
    check("R3 collide ready", 32'(bus_ready), 1);
    check("R3 collide data", bus_rdata, pat(8));
    check("R4 no valid", 32'(fetch_valid), 0);
    bus_req = 1'b0;
    #1;
    check("R5 gnt after bus", 32'(fetch_gnt), 1);
    check("R5 stall low", 32'(fetch_stall), 0);
    @(negedge clk);
    check("R5 valid", 32'(fetch_valid), 1);
    check("R5 held pc data", 32'(fetch_instr), 32'(exp_instr(5)));
    fetch_req = 1'b0;

    // R4: back-to-back bus writes against a waiting fetch
    @(negedge clk);
    fetch_req = 1'b1; fetch_pc = 16'd14;
    bus_req = 1'b1; bus_we = 1'b1; bus_size = 2'd2; bus_addr = AW'(28);
    bus_wdata = 32'hA1B2_C3D4;
    #1 check("R4 stall on write", 32'(fetch_stall), 1);
    @(negedge clk);
    check("R3 write ready", 32'(bus_ready), 1);
    bus_req = 1'b0; bus_we = 1'b0;
    @(negedge clk);
    check("R5 sees new word", 32'(fetch_instr), 32'h0000_C3D4);
    fetch_req = 1'b0;

    @(negedge clk);
    finish_up();
  end
endmodule